// File: doc/BRIEF.md
# Droop-Compensated Interpolate-by-8 Up-Sampler

This block raises a stream of signed fixed-point samples by a factor of eight. It is meant as the rate-raising front end of a digital up-converter. Two stages share the work. The first is a short polyphase FIR that doubles the rate. Its integer taps give a mild high-frequency lift, which offsets the sagging passband of the stage behind it. The second is a three-section cascaded integrator-comb (CIC) interpolator that multiplies the rate by four. It uses only adders, subtractors and registers.

The block runs on the output-rate clock. An internal slot counter opens one input slot every eight clocks and signals it on `ready_o`. The comb sections step once per FIR output, which is every four clocks. Zeros are stuffed between those steps. The integrator sections then run on every clock, so one output sample leaves per clock. Integrators carry full bit growth and wrap in two's complement. The result is cut back to the input width plus two bits.

Top module: `duc_interp8`

## Requirements
- R1: `ready_o` is high in exactly one clock of every eight. The first such clock is the one right after reset is released.
- R2: A sample is taken only when `valid_i` and `ready_o` are both high. `valid_i` and `data_i` in any other clock have no effect on `data_o`.
- R3: In a ready clock with `valid_i` low, a zero sample enters the chain in place of `data_i`.
- R4: The FIR keeps the last four accepted samples, newest first. Its first output uses taps (-1, 3, 15, -1) and its second output uses (-1, 15, 3, -1). Each sum is shifted right arithmetically by 4, giving a (width+1)-bit result. At twice the input rate, this is the response h = (-1, -1, 3, 15, 15, 3, -1, -1).
- R5: The CIC has three comb sections (differential delay 1) stepped once per FIR output. It inserts three zeros after each comb result and has three integrator sections stepped on every clock. Integrators hold width + 1 + 3·log2(4) bits and wrap.
- R6: `data_o` is the final integrator shifted right by 2·log2(4) bits, keeping width+2 bits. With a(c) = the sample taken in clock c (zero if none) and all taken samples multiples of 256, `data_o` in clock C equals the sum over j = 0..37 of a(C−5−j)·g(j), divided by 256. Here g(j) is the sum over m of h(m)·b(j−4m), and b = (1,3,6,10,12,12,10,6,3,1).
- R7: The asynchronous active-low reset clears every FIR, comb and integrator register and the slot counter. While reset is held, `data_o` is 0 and `ready_o` is 1.
- R8: `data_o` stays 0 until 5 clocks after the first non-zero sample is taken. It returns to exactly 0 once 43 clocks pass with no non-zero sample taken.
- R9: Full-scale inputs at either extreme, including alternating signs, follow R6 without wrap at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Output-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample present |
| data_i | input | DATA_W | Signed input sample |
| ready_o | output | 1 | Input slot open this clock |
| data_o | output | DATA_W+2 | Signed output sample, one per clock |

## Verification
The first input is a single impulse. It exposes the 38-point chain response, and with it the FIR tap order and the 5-clock latency. A long constant run shows the DC gain and the settled value of the wrapping integrators. Alternating full-scale values give the largest internal swing. A table of mixed values compares every output clock against a convolution computed in the bench. Further runs drive valid off-slot with junk data, leave slots empty while data is present, and reset in the middle of a run; each shows whether that stimulus leaks into the output.

// File: rtl/duc_interp8_pkg.sv
package duc_interp8_pkg;
  localparam int FIR_PHASES = 2;
  localparam int FIR_TAPS   = 4;
  localparam int FIR_NORM   = 4;  // log2 of per-phase tap sum
  localparam int FIR_HEAD   = 5;  // accumulator growth over input width

  // phase 1 taps are phase 0 taps reversed (symmetric prototype)
  function automatic int fir_coef(input int phase, input int k);
    int idx;
    idx = (phase == 0) ? k : FIR_TAPS - 1 - k;
    case (idx)
      0:       return -1;
      1:       return 3;
      2:       return 15;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/duc_fir_poly2.sv
module duc_fir_poly2
  import duc_interp8_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     shift_i,
  input  logic signed [DATA_W-1:0] din_i,
  input  logic                     phase_i,
  output logic signed [DATA_W:0]   dout_o
);
  localparam int ACC_W = DATA_W + FIR_HEAD;

  logic signed [DATA_W-1:0] tap_q [FIR_TAPS];
  logic signed [ACC_W-1:0]  acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < FIR_TAPS; k++) tap_q[k] <= '0;
    end else if (shift_i) begin
      tap_q[0] <= din_i;
      for (int k = 1; k < FIR_TAPS; k++) tap_q[k] <= tap_q[k-1];
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < FIR_TAPS; k++)
      acc += ACC_W'(tap_q[k]) * ACC_W'(fir_coef(int'(phase_i), k));
  end

  assign dout_o = acc[ACC_W-1:FIR_NORM];
endmodule

// File: rtl/duc_cic_comb.sv
module duc_cic_comb #(
  parameter int W = 23,
  parameter int N = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic signed [W-1:0] din_i,
  output logic signed [W-1:0] dout_o
);
  logic signed [W-1:0] stg [N+1];

  assign stg[0] = din_i;

  for (genvar i = 0; i < N; i++) begin : g_comb
    logic signed [W-1:0] dly_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   dly_q <= '0;
      else if (en_i) dly_q <= stg[i];
    end
    assign stg[i+1] = stg[i] - dly_q;
  end

  assign dout_o = stg[N];
endmodule

// File: rtl/duc_cic_integ.sv
module duc_cic_integ #(
  parameter int W = 23,
  parameter int N = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic signed [W-1:0] din_i,
  output logic signed [W-1:0] dout_o
);
  logic signed [W-1:0] stg [N+1];

  assign stg[0] = din_i;

  // each section registered: wraps modulo 2^W
  for (genvar i = 0; i < N; i++) begin : g_integ
    logic signed [W-1:0] sum_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sum_q <= '0;
      else         sum_q <= sum_q + stg[i];
    end
    assign stg[i+1] = sum_q;
  end

  assign dout_o = stg[N];
endmodule

// File: rtl/duc_interp8.sv
module duc_interp8
  import duc_interp8_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CIC_N  = 3,
  parameter int CIC_R  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] data_i,
  output logic                     ready_o,
  output logic signed [DATA_W+1:0] data_o
);
  localparam int RATE  = FIR_PHASES * CIC_R;
  localparam int CNT_W = $clog2(RATE);
  localparam int RLOG  = $clog2(CIC_R);
  localparam int FIR_W = DATA_W + 1;
  localparam int GROW  = CIC_N * RLOG;
  localparam int CIC_W = FIR_W + GROW;
  localparam int SHIFT = (CIC_N - 1) * RLOG;
  localparam int OUT_W = DATA_W + 2;

  logic [CNT_W-1:0]         slot_q;
  logic                     accept;
  logic                     comb_en;
  logic signed [DATA_W-1:0] fir_din;
  logic signed [FIR_W-1:0]  fir_out;
  logic signed [CIC_W-1:0]  comb_out;
  logic signed [CIC_W-1:0]  stuff_q;
  logic signed [CIC_W-1:0]  integ_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= slot_q + 1'b1;
  end

  assign ready_o = (slot_q == '0);
  assign accept  = ready_o & valid_i;
  assign fir_din = accept ? data_i : '0;
  // one comb step per FIR output, one clock after each FIR phase becomes valid
  assign comb_en = (slot_q[RLOG-1:0] == RLOG'(1));

  duc_fir_poly2 #(.DATA_W(DATA_W)) u_fir (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (ready_o),
    .din_i   (fir_din),
    .phase_i (slot_q[CNT_W-1]),
    .dout_o  (fir_out)
  );

  duc_cic_comb #(.W(CIC_W), .N(CIC_N)) u_comb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (comb_en),
    .din_i  (CIC_W'(fir_out)),
    .dout_o (comb_out)
  );

  // zero insertion: comb result for one clock, zero for the rest
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stuff_q <= '0;
    else         stuff_q <= comb_en ? comb_out : '0;
  end

  duc_cic_integ #(.W(CIC_W), .N(CIC_N)) u_integ (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (stuff_q),
    .dout_o (integ_out)
  );

  assign data_o = integ_out[SHIFT +: OUT_W];
endmodule

// File: rtl/duc_interp8_chk.sv
module duc_interp8_chk #(
  parameter int DATA_W = 16,
  parameter int CIC_N  = 3,
  parameter int CIC_R  = 4,
  parameter int CIC_W  = 23
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic signed [DATA_W-1:0] data_i,
  input logic                     ready_o,
  input logic signed [DATA_W+1:0] data_o,
  input logic signed [CIC_W-1:0]  stuff_i
);
  localparam int RATE  = 2 * CIC_R;
  localparam int CNT_W = $clog2(RATE);
  localparam int RLOG  = $clog2(CIC_R);
  localparam int TAIL  = 2 + CIC_N + 7 * CIC_R + CIC_N * (CIC_R - 1);

  logic [CNT_W-1:0] gap_q;
  logic             seen_q;
  logic [7:0]       idle_q;
  logic             take_nz;

  assign take_nz = valid_i & ready_o & (data_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '1;
      seen_q <= 1'b0;
      idle_q <= '0;
    end else begin
      gap_q  <= gap_q + 1'b1;
      seen_q <= seen_q | take_nz;
      if (take_nz)           idle_q <= '0;
      else if (idle_q != '1) idle_q <= idle_q + 1'b1;
    end
  end

  AST_READY_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o == (gap_q == '1)); // R1

  AST_STUFF_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stuff_i != '0) |-> (gap_q[RLOG-1:0] == RLOG'(1))); // R5

  AST_QUIET_BEFORE_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (data_o == '0)); // R8

  AST_QUIET_AFTER_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && (int'(idle_q) > TAIL)) |-> (data_o == '0)); // R8
endmodule

bind duc_interp8 duc_interp8_chk #(
  .DATA_W (DATA_W),
  .CIC_N  (CIC_N),
  .CIC_R  (CIC_R),
  .CIC_W  (CIC_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .data_i  (data_i),
  .ready_o (ready_o),
  .data_o  (data_o),
  .stuff_i (stuff_q)
);

// File: tb/duc_interp8_tb_top.sv
`timescale 1ns/1ps
module duc_interp8_tb_top;
  localparam int DATA_W = 16;
  localparam int G_LEN  = 38;
  localparam int LAT    = 5;
  localparam int HMAX   = 4096;
  // per slot: bit7 = valid, bits6:0 = signed multiple of 512
  localparam logic [7:0] TBL [16] = '{
    8'h85, 8'hFD, 8'hBF, 8'hC0, 8'h80, 8'h09, 8'h91, 8'hEC,
    8'h81, 8'hFF, 8'hA8, 8'h00, 8'hCE, 8'hA1, 8'h8C, 8'hF9
  };

  logic                     clk = 1'b0;
  logic                     rst_ni = 1'b0;
  logic                     valid_i = 1'b0;
  logic signed [DATA_W-1:0] data_i = '0;
  logic                     ready_o;
  logic signed [DATA_W+1:0] data_o;

  int n_checks = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 1'b0;
  int hist [HMAX];
  int g [G_LEN];

  always #2.5 clk = ~clk;

  duc_interp8 dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (data_i),
    .ready_o (ready_o),
    .data_o  (data_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  function automatic int expv(input int c);
    int s = 0;
    for (int j = 0; j < G_LEN; j++)
      if (c - LAT - j >= 0) s += hist[c - LAT - j] * g[j];
    return s / 256;
  endfunction

  task automatic step(input bit v, input int d, input string tag);
    int e;
    int a;
    e = expv(cyc);
    a = int'(data_o);
    check(a == e, tag, a, e);
    check(ready_o == ((cyc % 8) == 0), "R1", int'(ready_o), int'((cyc % 8) == 0));
    valid_i = v;
    data_i  = 16'(d);
    hist[cyc] = (ready_o && v) ? d : 0;
    cyc++;
    @(negedge clk);
  endtask

  task automatic slot(input bit v, input int m, input bit off_v, input string tag);
    step(v, m * 512, tag);
    for (int i = 0; i < 7; i++) step(off_v, 777 + i, tag);
  endtask

  task automatic restart();
    rst_ni = 1'b1;
    cyc = 0;
    foreach (hist[i]) hist[i] = 0;
  endtask

  initial begin
    int h2 [8] = '{-1, -1, 3, 15, 15, 3, -1, -1};
    int bk [10];
    foreach (bk[i]) bk[i] = 0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) bk[a+b+c]++;
    for (int j = 0; j < G_LEN; j++) begin
      g[j] = 0;
      for (int m = 0; m < 8; m++)
        if (j - 4*m >= 0 && j - 4*m < 10) g[j] += h2[m] * bk[j - 4*m];
    end
    foreach (hist[i]) hist[i] = 0;

    // R7 reset state
    repeat (3) @(negedge clk);
    check(data_o == '0, "R7", int'(data_o), 0);
    check(ready_o == 1'b1, "R7", int'(ready_o), 1);
    restart();

    // R8 quiet before any input
    for (int i = 0; i < 2; i++) slot(1'b0, 0, 1'b0, "R8");
    // R4 impulse exposes tap order and latency
    slot(1'b1, 16, 1'b0, "R4");
    for (int i = 0; i < 7; i++) slot(1'b0, 0, 1'b0, "R4");
    // R5 constant run: settles to unity gain
    for (int i = 0; i < 10; i++) slot(1'b1, 32, 1'b0, "R5");
    for (int i = 0; i < 6; i++) slot(1'b0, 0, 1'b0, "R5");
    // R6 mixed table
    for (int i = 0; i < 16; i++)
      slot(TBL[i][7], int'($signed(TBL[i][6:0])), 1'b0, "R6");
    for (int i = 0; i < 6; i++) slot(1'b0, 0, 1'b0, "R6");
    // R3 empty slots with live data on the bus
    for (int i = 0; i < 6; i++) begin
      slot(1'b1, 40, 1'b0, "R3");
      valid_i = 1'b0;
      step(1'b0, 40 * 512, "R3");
      for (int k = 0; k < 7; k++) step(1'b0, 0, "R3");
    end
    for (int i = 0; i < 6; i++) slot(1'b0, 0, 1'b0, "R3");
    // R2 valid and junk data outside the slot
    for (int i = 0; i < 6; i++) slot(1'b1, 10 - 5 * i, 1'b1, "R2");
    for (int i = 0; i < 6; i++) slot(1'b0, 0, 1'b1, "R2");
    // R9 full-scale alternating extremes
    for (int i = 0; i < 10; i++) slot(1'b1, (i % 2 == 0) ? -64 : 63, 1'b0, "R9");
    for (int i = 0; i < 4; i++) slot(1'b1, -64, 1'b0, "R9");
    for (int i = 0; i < 6; i++) slot(1'b0, 0, 1'b0, "R9");
    // R7 reset in the middle of a run
    for (int i = 0; i < 3; i++) slot(1'b1, 50, 1'b0, "R7");
    step(1'b1, 50 * 512, "R7");
    rst_ni = 1'b0;
    #1;
    check(data_o == '0, "R7", int'(data_o), 0);
    check(ready_o == 1'b1, "R7", int'(ready_o), 1);
    repeat (2) @(negedge clk);
    restart();
    slot(1'b1, -24, 1'b0, "R7");
    for (int i = 0; i < 7; i++) slot(1'b0, 0, 1'b0, "R8");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule